// File: doc/BRIEF.md
# Single-Cycle 32-bit Integer Core

This block is a small 32-bit processor that completes one instruction in every clock cycle. In each cycle it fetches a word from its internal instruction array at the current program counter. It reads two source registers from a 32-entry register file and runs one ALU operation. It may then read or write a word in its internal data array, writes the result back, and moves the program counter on. Nine instructions are supported:

- register-to-register: add, sub, and, or, slt;
- memory: lw, sw;
- control flow: beq, j.

Any other encoding runs as a no-op.

Programs are placed in the instruction array before reset is released, and the initial data words are placed in the data array the same way. While the core runs, a debug read port shows any register, and the program counter is visible at an output. The ALU signed-overflow flag is brought out as a status output. Overflow never traps, and the wrapped result is still written.

Top module: `scp_core`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the program counter becomes 0 at that edge. The reset is synchronous and active low.
- R2: Register-format instructions have opcode 0. Their fields are rs [25:21], rt [20:16], rd [15:11] and funct [5:0]. Funct 32 writes rs+rt to rd, 34 writes rs-rt, 36 writes rs AND rt, and 37 writes rs OR rt.
- R3: Funct 42 (slt) writes 1 to rd when rs is less than rt as signed 32-bit values, and 0 otherwise.
- R4: Register 0 always reads as zero, on the operand paths and on `dbg_rd`. A write aimed at register 0 is dropped.
- R5: Opcode 35 (lw) reads the data word at rs + sign-extended ins[15:0] and writes it to rt. The word index is the address divided by 4, modulo the array depth.
- R6: Opcode 43 (sw) stores rt to the data word at rs + sign-extended ins[15:0], using the same word indexing. A later lw from that address returns the stored value.
- R7: Opcode 4 (beq) sets the next PC to PC+4 plus the sign-extended ins[15:0] shifted left by two when rs equals rt, and to PC+4 otherwise.
- R8: Opcode 2 (j) sets the next PC to bits [31:28] of PC+4, followed by ins[25:0] and then two zero bits.
- R9: Every instruction other than beq and j advances the PC by 4. An unknown opcode, or a register-format instruction with an unlisted funct, writes no register and no memory.
- R10: `alu_ovf` is high while the current instruction is add, sub, lw, sw or beq and its ALU add or subtract overflows as a signed 32-bit operation. It is low for every other instruction.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; state changes on the rising edge |
| rst_n | input | 1 | Synchronous active-low reset of the program counter |
| dbg_ra | input | 5 | Register number for the debug read port |
| pc_o | output | 32 | Current program counter (byte address) |
| dbg_rd | output | 32 | Combinational contents of register `dbg_ra` |
| alu_ovf | output | 1 | Signed overflow of the current ALU add or subtract |

## Verification
Each instruction is replayed against a bench model of the instruction set. The bench compares the next PC, the destination register and the overflow flag after every step.

The bench deliberately hits several edge cases:
- additions and subtractions that cross the signed limits, which catches a missing or inverted overflow flag;
- slt on operands of opposite sign, which an unsigned compare gets wrong;
- writes aimed at register 0, which expose a register file that does not protect it;
- a store through a negative offset read back by a load, which exposes an immediate that is zero-extended or a swapped destination select;
- taken and untaken branches plus a jump, which catch a target computed without the shift or from the wrong PC;
- an unknown opcode and an unknown funct whose destination field names a live register, so a decoder that still enables the write corrupts that register.

// File: rtl/scp_pkg.sv
// Package: shared encodings and the control-word type of the single-cycle core.
// Assumes the fixed field layout of the nine supported instructions.
package scp_pkg;

    localparam int XLEN = 32;
    localparam int RAW  = 5;

    localparam logic [5:0] OP_RTYPE = 6'd0;
    localparam logic [5:0] OP_LW    = 6'd35;
    localparam logic [5:0] OP_SW    = 6'd43;
    localparam logic [5:0] OP_BEQ   = 6'd4;
    localparam logic [5:0] OP_J     = 6'd2;

    localparam logic [5:0] FN_ADD = 6'd32;
    localparam logic [5:0] FN_SUB = 6'd34;
    localparam logic [5:0] FN_AND = 6'd36;
    localparam logic [5:0] FN_OR  = 6'd37;
    localparam logic [5:0] FN_SLT = 6'd42;

    typedef enum logic [2:0] {
        ALU_AND = 3'b000,
        ALU_OR  = 3'b001,
        ALU_ADD = 3'b010,
        ALU_SUB = 3'b110,
        ALU_SLT = 3'b111
    } alu_op_e;

    typedef struct packed {
        logic    jump;
        logic    branch;
        logic    reg_we;
        logic    mem_re;
        logic    mem_we;
        logic    mem_to_reg;
        logic    alu_imm;
        logic    dst_rd;
        alu_op_e alu_op;
    } ctrl_t;

endpackage

// File: rtl/scp_ctrl.sv
// Module: scp_ctrl
// Decodes opcode and funct into the control word of the core.
// Assumes unknown encodings must act as no-ops: no writes, ALU set to AND (no overflow).
module scp_ctrl
    import scp_pkg::*;
(
    input  logic [5:0] opcode,
    input  logic [5:0] funct,
    output ctrl_t      ctrl
);

    // Purpose: map each supported instruction to its datapath controls.
    always_comb begin
        ctrl        = '0;
        ctrl.alu_op = ALU_AND;
        unique case (opcode)
            OP_RTYPE: begin
                ctrl.dst_rd = 1'b1;
                ctrl.reg_we = 1'b1;
                case (funct)
                    FN_ADD:  ctrl.alu_op = ALU_ADD;
                    FN_SUB:  ctrl.alu_op = ALU_SUB;
                    FN_AND:  ctrl.alu_op = ALU_AND;
                    FN_OR:   ctrl.alu_op = ALU_OR;
                    FN_SLT:  ctrl.alu_op = ALU_SLT;
                    default: ctrl.reg_we = 1'b0;
                endcase
            end
            OP_LW: begin
                ctrl.reg_we     = 1'b1;
                ctrl.mem_re     = 1'b1;
                ctrl.mem_to_reg = 1'b1;
                ctrl.alu_imm    = 1'b1;
                ctrl.alu_op     = ALU_ADD;
            end
            OP_SW: begin
                ctrl.mem_we  = 1'b1;
                ctrl.alu_imm = 1'b1;
                ctrl.alu_op  = ALU_ADD;
            end
            OP_BEQ: begin
                ctrl.branch = 1'b1;
                ctrl.alu_op = ALU_SUB;
            end
            OP_J: begin
                ctrl.jump = 1'b1;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/scp_alu.sv
// Module: scp_alu
// 32-bit ALU: and, or, add, sub, signed set-less-than; equality and overflow flags.
// Assumes the overflow flag is only meaningful for add and sub and is 0 otherwise.
module scp_alu
    import scp_pkg::*;
#(
    parameter int W = XLEN
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  alu_op_e      op,
    output logic [W-1:0] y,
    output logic         zero,
    output logic         ovf
);

    logic [W-1:0] sum;
    logic [W-1:0] diff;

    assign sum  = a + b;
    assign diff = a - b;

    // Purpose: select the result and overflow for the requested operation.
    always_comb begin
        y   = '0;
        ovf = 1'b0;
        case (op)
            ALU_AND: y = a & b;
            ALU_OR:  y = a | b;
            ALU_ADD: begin
                y   = sum;
                ovf = (a[W-1] == b[W-1]) && (sum[W-1] != a[W-1]);
            end
            ALU_SUB: begin
                y   = diff;
                ovf = (a[W-1] != b[W-1]) && (diff[W-1] != a[W-1]);
            end
            ALU_SLT: y = {{(W-1){1'b0}}, ($signed(a) < $signed(b))};
            default: y = '0;
        endcase
    end

    assign zero = (a == b);

endmodule

// File: rtl/scp_regfile.sv
// Module: scp_regfile
// Register file with three combinational read ports and one write port on the rising edge.
// Assumes entry 0 is hard-wired to zero; the third read port serves debug.
module scp_regfile #(
    parameter int W   = 32,
    parameter int AW  = 5,
    localparam int NR = 1 << AW
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] wa,
    input  logic [W-1:0]  wd,
    input  logic [AW-1:0] ra1,
    input  logic [AW-1:0] ra2,
    input  logic [AW-1:0] ra3,
    output logic [W-1:0]  rd1,
    output logic [W-1:0]  rd2,
    output logic [W-1:0]  rd3
);

    logic [W-1:0] regs [NR];

    // Purpose: capture the write-back value, dropping writes to entry 0.
    always_ff @(posedge clk) begin
        if (we && (wa != '0)) begin
            regs[wa] <= wd;
        end
    end

    logic [AW-1:0] ra   [3];
    logic [W-1:0]  rdat [3];

    assign ra[0] = ra1;
    assign ra[1] = ra2;
    assign ra[2] = ra3;

    for (genvar p = 0; p < 3; p++) begin : g_rport
        // Purpose: read one port, forcing zero for entry 0.
        assign rdat[p] = (ra[p] == '0) ? '0 : regs[ra[p]];
    end

    assign rd1 = rdat[0];
    assign rd2 = rdat[1];
    assign rd3 = rdat[2];

endmodule

// File: rtl/scp_core.sv
// Module: scp_core (top)
// Single-cycle core: fetch, decode, register read, ALU, data memory, write-back, next PC.
// Assumes program and initial data are placed in imem/dmem before reset is released.
module scp_core
    import scp_pkg::*;
#(
    parameter int IMEM_WORDS = 128,
    parameter int DMEM_WORDS = 64
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [RAW-1:0]  dbg_ra,
    output logic [XLEN-1:0] pc_o,
    output logic [XLEN-1:0] dbg_rd,
    output logic            alu_ovf
);

    localparam int IAW = $clog2(IMEM_WORDS);
    localparam int DAW = $clog2(DMEM_WORDS);

    logic [XLEN-1:0] imem [IMEM_WORDS];
    logic [XLEN-1:0] dmem [DMEM_WORDS];

    // Purpose: start the instruction array empty (all no-ops).
    initial begin
        for (int i = 0; i < IMEM_WORDS; i++) imem[i] = '0;
    end

    logic [XLEN-1:0] pc, pc_next, pc_plus4, br_tgt, jmp_tgt;
    logic [XLEN-1:0] instr, imm_sx;
    logic [XLEN-1:0] rs_val, rt_val, alu_b, alu_y, mem_rdata, wb_data;
    logic [RAW-1:0]  wa;
    logic            alu_zero;
    ctrl_t           ctrl;

    // Purpose: program counter register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) pc <= '0;
        else        pc <= pc_next;
    end

    assign instr  = imem[pc[IAW+1:2]];
    assign imm_sx = {{(XLEN-16){instr[15]}}, instr[15:0]};

    scp_ctrl u_ctrl (
        .opcode (instr[31:26]),
        .funct  (instr[5:0]),
        .ctrl   (ctrl)
    );

    assign wa = ctrl.dst_rd ? instr[15:11] : instr[20:16];

    scp_regfile #(.W(XLEN), .AW(RAW)) u_rf (
        .clk (clk),
        .we  (ctrl.reg_we),
        .wa  (wa),
        .wd  (wb_data),
        .ra1 (instr[25:21]),
        .ra2 (instr[20:16]),
        .ra3 (dbg_ra),
        .rd1 (rs_val),
        .rd2 (rt_val),
        .rd3 (dbg_rd)
    );

    assign alu_b = ctrl.alu_imm ? imm_sx : rt_val;

    scp_alu #(.W(XLEN)) u_alu (
        .a    (rs_val),
        .b    (alu_b),
        .op   (ctrl.alu_op),
        .y    (alu_y),
        .zero (alu_zero),
        .ovf  (alu_ovf)
    );

    // Purpose: store rt into the data array on sw.
    always_ff @(posedge clk) begin
        if (ctrl.mem_we) dmem[alu_y[DAW+1:2]] <= rt_val;
    end

    assign mem_rdata = ctrl.mem_re ? dmem[alu_y[DAW+1:2]] : '0;
    assign wb_data   = ctrl.mem_to_reg ? mem_rdata : alu_y;

    assign pc_plus4 = pc + 32'd4;
    assign br_tgt   = pc_plus4 + {imm_sx[XLEN-3:0], 2'b00};
    assign jmp_tgt  = {pc_plus4[31:28], instr[25:0], 2'b00};

    // Purpose: choose jump, taken branch or sequential next PC.
    always_comb begin
        if (ctrl.jump)                    pc_next = jmp_tgt;
        else if (ctrl.branch && alu_zero) pc_next = br_tgt;
        else                              pc_next = pc_plus4;
    end

    assign pc_o = pc;

    logic unused_bits;
    assign unused_bits = ^{instr[10:6], pc[XLEN-1:IAW+2], pc[1:0],
                           alu_y[XLEN-1:DAW+2], alu_y[1:0]};

endmodule

// File: rtl/scp_core_chk.sv
// Module: scp_core_chk
// Checker bound into scp_core: reset PC, register 0 and next-PC rules.
// Assumes it sees the core's PC, the current instruction and the ALU equality flag.
module scp_core_chk
    import scp_pkg::*;
(
    input logic            clk,
    input logic            rst_n,
    input logic [XLEN-1:0] pc,
    input logic [XLEN-1:0] instr,
    input logic            zero,
    input logic [RAW-1:0]  dbg_ra,
    input logic [XLEN-1:0] dbg_rd
);

    logic [5:0]      op;
    logic [XLEN-1:0] seq_pc, taken_pc, jump_pc;

    assign op       = instr[31:26];
    assign seq_pc   = pc + 32'd4;
    assign taken_pc = seq_pc + {{(XLEN-18){instr[15]}}, instr[15:0], 2'b00};
    assign jump_pc  = {seq_pc[31:28], instr[25:0], 2'b00};

    a_r1_reset_pc: assert property (@(posedge clk)
        !rst_n |=> pc == '0);

    a_r4_zero_reg: assert property (@(posedge clk) disable iff (!rst_n)
        dbg_ra == '0 |-> dbg_rd == '0);

    a_r9_seq_pc: assert property (@(posedge clk) disable iff (!rst_n)
        (op != OP_BEQ && op != OP_J) |=> pc == $past(seq_pc));

    a_r7_beq_taken: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_BEQ && zero) |=> pc == $past(taken_pc));

    a_r7_beq_fall: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_BEQ && !zero) |=> pc == $past(seq_pc));

    a_r8_jump: assert property (@(posedge clk) disable iff (!rst_n)
        op == OP_J |=> pc == $past(jump_pc));

endmodule

bind scp_core scp_core_chk u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .pc     (pc),
    .instr  (instr),
    .zero   (alu_zero),
    .dbg_ra (dbg_ra),
    .dbg_rd (dbg_rd)
);

// File: tb/sim_scp_core.sv
// Bench for scp_core: directed corner cases plus seeded random instructions,
// each step compared against an instruction-level model kept in the bench.
module sim_scp_core;

    localparam int IMW = 128;
    localparam int DMW = 64;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  dbg_ra = '0;
    logic [31:0] pc_o, dbg_rd;
    logic        alu_ovf;

    always #10 clk = ~clk;

    scp_core #(.IMEM_WORDS(IMW), .DMEM_WORDS(DMW)) u0 (
        .clk     (clk),
        .rst_n   (rst_n),
        .dbg_ra  (dbg_ra),
        .pc_o    (pc_o),
        .dbg_rd  (dbg_rd),
        .alu_ovf (alu_ovf)
    );

    int          n_chk = 0;
    int          n_bad = 0;
    logic [31:0] prog [IMW];
    logic [31:0] mreg [32];
    logic [31:0] mdm  [DMW];
    logic [31:0] mpc;
    int          plen;

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s at pc=%h: actual=%h expected=%h", req, mpc, act, exp);
        end
    endtask

    function automatic logic [31:0] enc_r(input logic [5:0] fn, input int rs, rt, rd);
        return {6'd0, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
    endfunction

    function automatic logic [31:0] enc_i(input logic [5:0] op, input int rs, rt,
                                          input logic [15:0] imm);
        return {op, 5'(rs), 5'(rt), imm};
    endfunction

    function automatic logic [31:0] enc_j(input int word);
        return {6'd2, 26'(word)};
    endfunction

    function automatic logic add_ovf(input logic [31:0] a, b);
        logic [31:0] s = a + b;
        return (a[31] == b[31]) && (s[31] != a[31]);
    endfunction

    function automatic logic sub_ovf(input logic [31:0] a, b);
        logic [31:0] d = a - b;
        return (a[31] != b[31]) && (d[31] != a[31]);
    endfunction

    // One instruction: predict, clock, compare PC and the affected register.
    task automatic step();
        logic [31:0] ins, a, b, imm, addr, res, nxt;
        logic [5:0]  op, fn;
        int          dest;
        bit          store;
        logic        eovf;
        string       req;
        ins   = prog[(mpc >> 2) % IMW];
        op    = ins[31:26];
        fn    = ins[5:0];
        a     = (ins[25:21] == 0) ? 32'd0 : mreg[ins[25:21]];
        b     = (ins[20:16] == 0) ? 32'd0 : mreg[ins[20:16]];
        imm   = {{16{ins[15]}}, ins[15:0]};
        nxt   = mpc + 4;
        dest  = -1;
        store = 0;
        eovf  = 0;
        res   = '0;
        addr  = '0;
        req   = "R9";
        case (op)
            6'd0: begin
                dest = ins[15:11];
                case (fn)
                    6'd32: begin res = a + b; eovf = add_ovf(a, b); req = "R2"; end
                    6'd34: begin res = a - b; eovf = sub_ovf(a, b); req = "R2"; end
                    6'd36: begin res = a & b; req = "R2"; end
                    6'd37: begin res = a | b; req = "R2"; end
                    6'd42: begin res = ($signed(a) < $signed(b)) ? 32'd1 : 32'd0; req = "R3"; end
                    default: res = mreg[dest];
                endcase
            end
            6'd35: begin
                addr = a + imm; eovf = add_ovf(a, imm);
                dest = ins[20:16]; res = mdm[(addr >> 2) % DMW]; req = "R5";
            end
            6'd43: begin
                addr = a + imm; eovf = add_ovf(a, imm); store = 1; req = "R6";
            end
            6'd4: begin
                eovf = sub_ovf(a, b); req = "R7";
                if (a == b) nxt = mpc + 4 + {imm[29:0], 2'b00};
            end
            6'd2: begin
                nxt = {nxt[31:28], ins[25:0], 2'b00}; req = "R8";
            end
            default: begin
                dest = ins[20:16]; res = mreg[dest];
            end
        endcase
        chk(alu_ovf === eovf, "R10", {31'd0, alu_ovf}, {31'd0, eovf});
        @(posedge clk);
        @(negedge clk);
        if (dest > 0) mreg[dest] = res;
        if (store) mdm[(addr >> 2) % DMW] = b;
        mpc = nxt;
        chk(pc_o === mpc, req, pc_o, mpc);
        if (dest >= 0) begin
            dbg_ra = 5'(dest);
            #1;
            chk(dbg_rd === mreg[dest], (dest == 0) ? "R4" : req, dbg_rd, mreg[dest]);
        end
    endtask

    // Watchdog: a hung run is a failed check.
    initial begin
        #(20 * 200000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual=running expected=done");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        int p;
        void'($urandom(32'd20240611));
        for (int i = 0; i < 32; i++) mreg[i] = '0;
        for (int i = 0; i < DMW; i++) mdm[i] = $urandom;
        mdm[0] = 32'h7fff_ffff;
        mdm[1] = 32'h0000_0001;
        mdm[2] = 32'h8000_0000;
        mdm[3] = 32'hffff_fffb;
        mdm[4] = 32'h0000_0040;
        for (int i = 0; i < IMW; i++) prog[i] = '0;
        p = 0;
        for (int r = 1; r < 16; r++) begin prog[p] = enc_i(6'd35, 0, r, 16'(4 * (r - 1))); p++; end
        prog[p] = enc_r(6'd32, 1, 2, 9);   p++; // R2/R10 add overflow
        prog[p] = enc_r(6'd34, 3, 2, 10);  p++; // R2/R10 sub overflow
        prog[p] = enc_r(6'd36, 6, 7, 11);  p++;
        prog[p] = enc_r(6'd37, 6, 7, 12);  p++;
        prog[p] = enc_r(6'd42, 4, 5, 13);  p++; // R3 negative < positive
        prog[p] = enc_r(6'd42, 5, 4, 13);  p++; // R3 positive vs negative
        prog[p] = enc_r(6'd42, 3, 1, 13);  p++; // R3 most negative < most positive
        prog[p] = enc_r(6'd32, 1, 1, 0);   p++; // R4 write to r0
        prog[p] = enc_i(6'd43, 5, 9, 16'hfffc); p++; // R6 negative offset
        prog[p] = enc_i(6'd35, 0, 14, 16'd60);  p++; // R5 read back
        prog[p] = enc_i(6'd4, 1, 2, 16'd3);     p++; // R7 not taken
        prog[p] = enc_i(6'd4, 6, 6, 16'd2);     p++; // R7 taken
        prog[p] = enc_r(6'd32, 1, 1, 15);       p++;
        prog[p] = enc_r(6'd32, 1, 1, 15);       p++;
        prog[p] = {6'h3f, 5'd1, 5'd12, 16'h0004}; p++; // R9 unknown opcode
        prog[p] = enc_r(6'd0, 1, 2, 11);        p++; // R9 unknown funct
        prog[p] = enc_j(p + 2);                 p++; // R8
        prog[p] = enc_r(6'd32, 1, 1, 14);       p++;
        for (int k = 0; k < 40; k++) begin
            int kind = int'($urandom % 8);
            if (kind < 6) begin
                logic [5:0] fns [5] = '{6'd32, 6'd34, 6'd36, 6'd37, 6'd42};
                prog[p] = enc_r(fns[$urandom % 5], int'($urandom % 16),
                                int'($urandom % 16), int'($urandom % 16));
            end else if (kind == 6) begin
                prog[p] = enc_i(6'd43, 0, int'($urandom % 16), 16'(4 * (16 + $urandom % 48)));
            end else begin
                prog[p] = enc_i(6'd35, 0, int'(1 + $urandom % 15), 16'(4 * (16 + $urandom % 48)));
            end
            p++;
        end
        plen = p;

        #1;
        for (int i = 0; i < IMW; i++) u0.imem[i] = prog[i];
        for (int i = 0; i < DMW; i++) u0.dmem[i] = mdm[i];

        @(negedge clk);
        @(negedge clk);
        mpc = '0;
        chk(pc_o === 32'd0, "R1", pc_o, 32'd0);
        rst_n = 1'b1;
        while ((mpc >> 2) < plen) step();

        rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        mpc = '0;
        chk(pc_o === 32'd0, "R1", pc_o, 32'd0);

        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule